// File: doc/BRIEF.md
# Two-Channel LO Mixer with Zero Insertion and Trim

This block sits between an interpolation chain and a pair of DAC cores. It takes two signed sample streams (I and Q) at the output sample rate. It multiplies them by a local oscillator whose frequency is a fixed fraction of that rate: one half, one quarter or one eighth. It can also pass the samples through unmixed. The LO frequencies are simple ratios, so the cosine and sine values come from one small eight-entry table indexed by a three-bit phase counter, and no oscillator arithmetic is needed.

The two channels can work on their own, each stream mixed with a real cosine. They can also be coupled into a complex modulator that feeds an external analog quadrature stage for image-reject transmission. A zero-insertion option replaces every second sample with zero, which flattens the pass band against the DAC's sin(x)/x droop. Last, each channel scales its result by its own gain, adds its own offset and clamps the sum to the output word. This trim lets the system balance the two DAC paths and null LO feedthrough.

Top module: `iq_lo_mixer`

## Requirements
- R1: While `rst_n` is low at a rising edge, both outputs become 0 and the LO phase counter returns to 0.
- R2: `lo_sel` encodes the LO: 0 = no mixing (cos = 1, sin = 0), 1 = half rate, 2 = quarter rate, 3 = eighth rate. With no mixing, channel A carries I and channel B carries Q, each through its own trim.
- R3: At half rate the cosine alternates +1, −1 over consecutive samples, starting at +1, and the sine is 0.
- R4: At quarter rate the cosine runs 1, 0, −1, 0 and the sine runs 0, 1, 0, −1, starting from phase 0.
- R5: At eighth rate the coefficients are cos and sin of k·45° for phase k = 0..7. Unity is 8192 (13 fractional bits), and 0.7071 is held as 5793. Each mixed term is the product sum divided by 8192, rounded toward minus infinity.
- R6: With `coupled` = 0 the channels are independent: A = I·cos and B = Q·cos.
- R7: With `coupled` = 1 the pair is a complex modulator: A = I·cos − Q·sin and B = I·sin + Q·cos.
- R8: The phase counter advances by one per sample. It restarts at 0 for the sample presented in any cycle where `lo_sel`, `coupled` or `zstuff` differs from its value in the previous cycle.
- R9: With `zstuff` = 1, a sample presented at an odd phase is replaced by zero before mixing, and the input values on those cycles have no effect on the outputs.
- R10: After mixing, each channel multiplies by its gain, an unsigned value with 10 fractional bits (1024 = unity), rounds toward minus infinity, then adds its signed 14-bit offset.
- R11: A trimmed result above 8191 leaves the block as 8191, and one below −8192 leaves it as −8192. It never wraps.
- R12: A sample presented before rising edge n shows on the outputs after edge n+2, in every mode. All configuration inputs are taken at the same edge as the sample they apply to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_sel | input | 2 | LO select (0 none, 1 half, 2 quarter, 3 eighth rate) |
| coupled | input | 1 | 1 = complex modulator, 0 = independent channels |
| zstuff | input | 1 | 1 = replace odd-phase samples with zero |
| in_i | input | 14 | Signed I sample |
| in_q | input | 14 | Signed Q sample |
| gain_a | input | 12 | Channel A gain, unsigned, 10 fractional bits |
| gain_b | input | 12 | Channel B gain, unsigned, 10 fractional bits |
| ofs_a | input | 14 | Channel A signed offset |
| ofs_b | input | 14 | Channel B signed offset |
| out_a | output | 14 | Channel A signed result |
| out_b | output | 14 | Channel B signed result |

## Verification
The bench builds the block with its default parameters: 14-bit samples, a 15-bit coefficient with 13 fractional bits, and a 12-bit gain with 10 fractional bits. At these values the 5793 diagonal coefficient and floor rounding give exact integers to compare against. Gain codes up to almost four make both saturation limits reachable from full-scale inputs. Offsets at the ends of their range push in-range mixed values past the clamp. The bench derives its cosine and sine values from real trigonometry, so a wrong table entry, a wrong phase step or a missed phase restart on a configuration change all show up as a mismatch at the expected cycle.

// File: rtl/mixer_pkg.sv
// Shared types and helpers for the LO mixer.
// Assumes a 3-bit phase index over one eighth-rate LO period.
package mixer_pkg;

    typedef enum logic [1:0] {
        LO_NONE    = 2'd0,
        LO_HALF    = 2'd1,
        LO_QUARTER = 2'd2,
        LO_EIGHTH  = 2'd3
    } lo_sel_e;

    // Cosine of idx*45 degrees scaled by 2**frac, diagonal rounded to nearest.
    function automatic int lo_coef(input logic [2:0] idx, input int frac);
        int one;
        int diag;
        one  = 1 << frac;
        diag = int'((longint'(46341) * (longint'(1) << frac) + 64'sd32768) >>> 16);
        case (idx)
            3'd0:    lo_coef = one;
            3'd1:    lo_coef = diag;
            3'd2:    lo_coef = 0;
            3'd3:    lo_coef = -diag;
            3'd4:    lo_coef = -one;
            3'd5:    lo_coef = -diag;
            3'd6:    lo_coef = 0;
            default: lo_coef = diag;
        endcase
    endfunction

endpackage

// File: rtl/lo_phase_gen.sv
// LO phase counter and coefficient lookup.
// Gives the cosine/sine pair for the sample presented this cycle and
// flags odd phases for zero insertion. Restarts phase on any mode change.
// Assumes COEF_W >= COEF_FRAC + 2 so that unity fits.
module lo_phase_gen
    import mixer_pkg::*;
#(
    parameter int COEF_W    = 15,
    parameter int COEF_FRAC = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               lo_sel,
    input  logic                     coupled,
    input  logic                     zstuff,
    output logic signed [COEF_W-1:0] cos_o,
    output logic signed [COEF_W-1:0] sin_o,
    output logic                     slot_odd_o
);
    localparam int CFG_W = 4;

    logic [2:0]       ph_q;
    logic [2:0]       ph_use;
    logic [2:0]       idx;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;

    // Detect a configuration change and pick the phase for this sample.
    always_comb begin
        cfg_now = {lo_sel, coupled, zstuff};
        cfg_chg = (cfg_now != cfg_q);
        ph_use  = cfg_chg ? 3'd0 : ph_q;
    end

    // Map phase onto the eighth-rate table according to the LO choice.
    always_comb begin
        case (lo_sel_e'(lo_sel))
            LO_HALF:    idx = {ph_use[0], 2'b00};
            LO_QUARTER: idx = {ph_use[1:0], 1'b0};
            LO_EIGHTH:  idx = ph_use;
            default:    idx = 3'd0;
        endcase
        cos_o      = COEF_W'(lo_coef(idx, COEF_FRAC));
        sin_o      = COEF_W'(lo_coef(idx - 3'd2, COEF_FRAC));
        slot_odd_o = ph_use[0];
    end

    // Advance the phase and remember the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= 3'd0;
            cfg_q <= cfg_now;
        end else begin
            ph_q  <= ph_use + 3'd1;
            cfg_q <= cfg_now;
        end
    end

    // R8: a change restarts the sequence, so the next stored phase is 1.
    a_r8_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (ph_q == 3'd1));

    // R8: without a change the phase steps by exactly one.
    a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |=> (ph_q == $past(ph_q) + 3'd1));

endmodule

// File: rtl/cmplx_mix.sv
// Two pipeline stages: capture samples, coefficients and trim settings
// (zero insertion applied here), then form the real or complex product.
// Assumes the coefficient scale 2**COEF_FRAC is unity.
module cmplx_mix #(
    parameter int SAMP_W    = 14,
    parameter int COEF_W    = 15,
    parameter int COEF_FRAC = 13,
    parameter int GAIN_W    = 12,
    parameter int MIX_W     = SAMP_W + COEF_W + 1 - COEF_FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    input  logic signed [COEF_W-1:0] cos_i,
    input  logic signed [COEF_W-1:0] sin_i,
    input  logic                     coupled,
    input  logic                     zstuff,
    input  logic                     slot_odd,
    input  logic [GAIN_W-1:0]        gain_i [2],
    input  logic signed [SAMP_W-1:0] ofs_i  [2],
    output logic signed [MIX_W-1:0]  mix_o  [2],
    output logic [GAIN_W-1:0]        gain_o [2],
    output logic signed [SAMP_W-1:0] ofs_o  [2]
);
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int SUM_W  = PROD_W + 1;

    logic signed [SAMP_W-1:0] s1_i, s1_q;
    logic signed [COEF_W-1:0] s1_cos, s1_sin;
    logic                     s1_cpl;
    logic [GAIN_W-1:0]        s1_gain [2];
    logic signed [SAMP_W-1:0] s1_ofs  [2];
    logic                     kill;
    logic signed [PROD_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [SUM_W-1:0]  sum_a, sum_b;

    assign kill = zstuff && slot_odd;

    // Stage 1: register the sample (zeroed on odd stuffing slots) and settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_i   <= '0;
            s1_q   <= '0;
            s1_cos <= '0;
            s1_sin <= '0;
            s1_cpl <= 1'b0;
            for (int c = 0; c < 2; c++) begin
                s1_gain[c] <= '0;
                s1_ofs[c]  <= '0;
            end
        end else begin
            s1_i   <= kill ? '0 : in_i;
            s1_q   <= kill ? '0 : in_q;
            s1_cos <= cos_i;
            s1_sin <= sin_i;
            s1_cpl <= coupled;
            for (int c = 0; c < 2; c++) begin
                s1_gain[c] <= gain_i[c];
                s1_ofs[c]  <= ofs_i[c];
            end
        end
    end

    // Form the four partial products and combine them per mode.
    always_comb begin
        p_ic  = s1_i * s1_cos;
        p_qs  = s1_q * s1_sin;
        p_is  = s1_i * s1_sin;
        p_qc  = s1_q * s1_cos;
        sum_a = s1_cpl ? (SUM_W'(p_ic) - SUM_W'(p_qs)) : SUM_W'(p_ic);
        sum_b = s1_cpl ? (SUM_W'(p_is) + SUM_W'(p_qc)) : SUM_W'(p_qc);
    end

    // Stage 2: scale back to sample units and carry the trim settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                mix_o[c]  <= '0;
                gain_o[c] <= '0;
                ofs_o[c]  <= '0;
            end
        end else begin
            mix_o[0] <= MIX_W'(sum_a >>> COEF_FRAC);
            mix_o[1] <= MIX_W'(sum_b >>> COEF_FRAC);
            for (int c = 0; c < 2; c++) begin
                gain_o[c] <= s1_gain[c];
                ofs_o[c]  <= s1_ofs[c];
            end
        end
    end

    // R9: an odd slot with insertion enabled reaches the multipliers as zero.
    a_r9_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (s1_i == '0 && s1_q == '0));

    // R6: an independent pair with zero Q input gives zero on channel B.
    a_r6_indep_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_cpl && s1_q == '0) |=> (mix_o[1] == '0));

endmodule

// File: rtl/gain_trim.sv
// One channel's trim stage: gain multiply, offset add, clamp, register.
// Assumes the sum word is wider than the output word.
module gain_trim #(
    parameter int SAMP_W    = 14,
    parameter int MIX_W     = 17,
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [MIX_W-1:0]  mix_i,
    input  logic [GAIN_W-1:0]        gain_i,
    input  logic signed [SAMP_W-1:0] ofs_i,
    output logic signed [SAMP_W-1:0] out_o
);
    localparam int PW    = MIX_W + GAIN_W + 1;
    localparam int SH_W  = PW - GAIN_FRAC;
    localparam int SUM_W = SH_W + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(2 ** (SAMP_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(2 ** (SAMP_W - 1));

    logic signed [PW-1:0]    prod;
    logic signed [SH_W-1:0]  shd;
    logic signed [SUM_W-1:0] sum;

    // Scale by the gain and add the offset at full width.
    always_comb begin
        prod = mix_i * $signed({1'b0, gain_i});
        shd  = SH_W'(prod >>> GAIN_FRAC);
        sum  = SUM_W'(shd) + SUM_W'(ofs_i);
    end

    // Clamp into the output range and register.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_o <= '0;
        else if (sum > HI)  out_o <= SAMP_W'(HI);
        else if (sum < LO)  out_o <= SAMP_W'(LO);
        else                out_o <= SAMP_W'(sum);
    end

    // R11: overflow upward pins the output at the top value.
    a_r11_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sum > HI) |=> (out_o == SAMP_W'(HI)));

    // R11: overflow downward pins the output at the bottom value.
    a_r11_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (sum < LO) |=> (out_o == SAMP_W'(LO)));

endmodule

// File: rtl/iq_lo_mixer.sv
// Top level: LO generation, real/complex mixing with optional zero
// insertion, then per-channel gain, offset and clamp. Three-register path.
// Assumes in_i/in_q arrive at the output sample rate, one per clock.
module iq_lo_mixer #(
    parameter int SAMP_W    = 14,
    parameter int COEF_W    = 15,
    parameter int COEF_FRAC = 13,
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               lo_sel,
    input  logic                     coupled,
    input  logic                     zstuff,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    input  logic [GAIN_W-1:0]        gain_a,
    input  logic [GAIN_W-1:0]        gain_b,
    input  logic signed [SAMP_W-1:0] ofs_a,
    input  logic signed [SAMP_W-1:0] ofs_b,
    output logic signed [SAMP_W-1:0] out_a,
    output logic signed [SAMP_W-1:0] out_b
);
    localparam int MIX_W = SAMP_W + COEF_W + 1 - COEF_FRAC;
    localparam int NCH   = 2;

    logic signed [COEF_W-1:0] cos_w, sin_w;
    logic                     slot_odd;
    logic [GAIN_W-1:0]        gain_in [NCH];
    logic signed [SAMP_W-1:0] ofs_in  [NCH];
    logic signed [MIX_W-1:0]  mix_w   [NCH];
    logic [GAIN_W-1:0]        gain_w  [NCH];
    logic signed [SAMP_W-1:0] ofs_w   [NCH];
    logic signed [SAMP_W-1:0] out_w   [NCH];

    // Gather per-channel settings into arrays.
    always_comb begin
        gain_in[0] = gain_a;
        gain_in[1] = gain_b;
        ofs_in[0]  = ofs_a;
        ofs_in[1]  = ofs_b;
    end

    lo_phase_gen #(.COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_lo (
        .clk(clk), .rst_n(rst_n), .lo_sel(lo_sel), .coupled(coupled),
        .zstuff(zstuff), .cos_o(cos_w), .sin_o(sin_w), .slot_odd_o(slot_odd)
    );

    cmplx_mix #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
                .GAIN_W(GAIN_W), .MIX_W(MIX_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q),
        .cos_i(cos_w), .sin_i(sin_w), .coupled(coupled), .zstuff(zstuff),
        .slot_odd(slot_odd), .gain_i(gain_in), .ofs_i(ofs_in),
        .mix_o(mix_w), .gain_o(gain_w), .ofs_o(ofs_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_trim
        gain_trim #(.SAMP_W(SAMP_W), .MIX_W(MIX_W), .GAIN_W(GAIN_W),
                    .GAIN_FRAC(GAIN_FRAC)) u_trim (
            .clk(clk), .rst_n(rst_n), .mix_i(mix_w[c]), .gain_i(gain_w[c]),
            .ofs_i(ofs_w[c]), .out_o(out_w[c])
        );
    end

    assign out_a = out_w[0];
    assign out_b = out_w[1];

    // R2: with no mixing, zero input, unity gain and zero offset, the result is zero three edges later.
    a_r2_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_sel == 2'd0 && in_i == '0 && gain_a != '0 && ofs_a == '0)
        |=> ##2 ($past(rst_n, 2) ? (out_a == '0) : 1'b1));

endmodule

// File: tb/sim_iq_lo_mixer.sv
`timescale 1ns/1ps
module sim_iq_lo_mixer;
    localparam int SW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] lo_sel = 2'd0;
    logic coupled = 1'b0, zstuff = 1'b0;
    logic signed [SW-1:0] in_i = '0, in_q = '0, ofs_a = '0, ofs_b = '0;
    logic [11:0] gain_a = 12'd1024, gain_b = 12'd1024;
    logic signed [SW-1:0] out_a, out_b;

    iq_lo_mixer u0 (.clk(clk), .rst_n(rst_n), .lo_sel(lo_sel), .coupled(coupled),
        .zstuff(zstuff), .in_i(in_i), .in_q(in_q), .gain_a(gain_a), .gain_b(gain_b),
        .ofs_a(ofs_a), .ofs_b(ofs_b), .out_a(out_a), .out_b(out_b));

    always #2 clk = ~clk;

    typedef struct { int due; int ea; int eb; string tag; } exp_t;
    exp_t sb[$];
    int cyc = 0, n_chk = 0, n_fail = 0;
    // test-side settings, copied to the ports only inside drive()
    int t_lo = 0, t_cpl = 0, t_zs = 0, t_ga = 1024, t_gb = 1024, t_oa = 0, t_ob = 0;
    string tag = "R2";
    int m_ph = 0, m_prev = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int cfg_code();
        return t_lo * 4 + t_cpl * 2 + t_zs;
    endfunction

    function automatic int trig(input int k, input bit want_sin);
        real a;
        a = 3.14159265358979 * k / 4.0;
        return want_sin ? int'(8192.0 * $sin(a)) : int'(8192.0 * $cos(a));
    endfunction

    function automatic int trim(input longint m, input int g, input int o);
        longint v;
        v = ((m * g) >>> 10) + o;
        if (v > 8191) v = 8191;
        if (v < -8192) v = -8192;
        return int'(v);
    endfunction

    task automatic chk(input string r, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", r, act, exp_v, cyc);
        end
    endtask

    // driver: apply one sample with the current settings and predict its result
    task automatic drive(input int i, input int q);
        int ph, step, c, s;
        longint mi, mq, ma, mb;
        exp_t e;
        @(negedge clk);
        lo_sel = 2'(t_lo); coupled = t_cpl[0]; zstuff = t_zs[0];
        gain_a = 12'(t_ga); gain_b = 12'(t_gb); ofs_a = SW'(t_oa); ofs_b = SW'(t_ob);
        in_i = SW'(i); in_q = SW'(q);
        ph = (cfg_code() != m_prev) ? 0 : m_ph;   // R8
        m_ph = (ph + 1) % 8;
        m_prev = cfg_code();
        step = (t_lo == 1) ? 4 : (t_lo == 2) ? 2 : (t_lo == 3) ? 1 : 0;
        c = trig((ph * step) % 8, 1'b0);
        s = trig((ph * step) % 8, 1'b1);
        mi = i; mq = q;
        if (t_zs != 0 && (ph % 2) == 1) begin mi = 0; mq = 0; end   // R9
        if (t_cpl != 0) begin                                      // R7
            ma = (mi * c - mq * s) >>> 13;
            mb = (mi * s + mq * c) >>> 13;
        end else begin                                             // R6
            ma = (mi * c) >>> 13;
            mb = (mq * c) >>> 13;
        end
        e.due = cyc + 3;                                           // R12
        e.ea = trim(ma, t_ga, t_oa);
        e.eb = trim(mb, t_gb, t_ob);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare results as they become due
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].due == cyc) begin
                chk({sb[0].tag, " A"}, int'(out_a), sb[0].ea);
                chk({sb[0].tag, " B"}, int'(out_b), sb[0].eb);
                void'(sb.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int lcg;
        lcg = 12345;
        idle(4);
        chk("R1 reset A", int'(out_a), 0);
        chk("R1 reset B", int'(out_b), 0);
        m_ph = 0; m_prev = cfg_code();
        @(negedge clk); rst_n = 1'b1;

        tag = "R2";  for (int k = 0; k < 6; k++) drive(100 * k - 250, 37 - 90 * k);
        tag = "R3";  t_lo = 1; for (int k = 0; k < 8; k++) drive(1000 + k, -2000 + 3 * k);
        tag = "R4";  t_lo = 2; t_cpl = 1; for (int k = 0; k < 10; k++) drive(3000 - 7 * k, 1500 + 11 * k);
        tag = "R5";  t_lo = 3; for (int k = 0; k < 16; k++) drive(5000 - 333 * k, -4000 + 517 * k);
        tag = "R6";  t_cpl = 0; for (int k = 0; k < 16; k++) drive(-7000 + 901 * k, 6000 - 777 * k);
        tag = "R7";  t_cpl = 1; t_lo = 3; for (int k = 0; k < 8; k++) drive(8191, -8192);
        tag = "R8";  for (int k = 0; k < 3; k++) drive(2000, 1000);
        t_lo = 2; drive(2000, 1000); drive(2000, 1000);
        t_zs = 1; drive(2000, 1000); drive(2000, 1000);
        t_cpl = 0; drive(2000, 1000); t_lo = 1; drive(2000, 1000);
        tag = "R9";  t_lo = 2; t_cpl = 1;
        for (int k = 0; k < 12; k++) drive((k % 2 == 1) ? 8000 : 1234, (k % 2 == 1) ? -8000 : -321);
        tag = "R9";  t_lo = 0; t_cpl = 0; t_oa = 55; t_ob = -66;
        for (int k = 0; k < 6; k++) drive(5000, 5000);
        tag = "R10"; t_zs = 0; t_ga = 512; t_gb = 1536; t_oa = 300; t_ob = -300;
        for (int k = 0; k < 8; k++) drive(-999 + 401 * k, 777 - 203 * k);
        tag = "R11"; t_ga = 4095; t_gb = 4095; t_oa = 0; t_ob = 0;
        drive(8191, -8192); drive(-8192, 8191); drive(2050, -2050);
        t_ga = 1024; t_gb = 1024; t_oa = 8191; t_ob = -8192;
        drive(8000, -8000); drive(-100, 100);
        tag = "R12"; t_oa = 0; t_ob = 0;
        for (int k = 0; k < 40; k++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            t_ga = lcg % 4096; t_gb = (lcg / 7) % 4096;
            t_oa = (lcg % 2001) - 1000; t_ob = ((lcg / 3) % 2001) - 1000;
            if (k % 10 == 0) begin t_lo = (lcg / 11) % 4; t_cpl = (lcg / 13) % 2; t_zs = (lcg / 17) % 2; end
            drive((lcg % 16384) - 8192, ((lcg / 5) % 16384) - 8192);
        end
        idle(6);
        chk("R12 drained", sb.size(), 0);
        summary();
    end
endmodule